// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR flash bus. It watches each bus write (address and data) and recognises the multi-cycle command sequences that a host uses to program a byte, erase the whole array, erase a chosen set of sectors, pause and continue a sector erase, and read identification codes. Each sequence opens with the same two unlock writes. Any write that breaks a sequence, or the reset data value, returns the decoder to plain array reads.

When a sequence completes, the decoder sends a one-cycle start pulse with its operands to the embedded program/erase engine. The engine reports completion with a done pulse. Sector erase first opens a collection window, counted in clock cycles. Each extra sector written inside the window adds that sector to the set and starts the window again. Per-sector protect inputs stop program and erase requests on protected sectors. While the identification mode is active, a read port returns the manufacturer, device and continuation codes and the protect status of each sector.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `as_mode`, `window_open` and `erase_suspended` are 0, and no start, suspend or resume pulse is issued.
- R2: A command needs two unlock writes: low 11 address bits 555h with data AAh, then low 11 address bits 2AAh with data 55h. Address bits 18..11 are don't care. A write with the wrong address or data returns the decoder to array read with no effect.
- R3: Unlocks followed by 555h/A0h and then one write at the target address issue `pgm_start` for one cycle, one clock after that write, carrying that address and data. Until `eng_done`, every write is ignored.
- R4: A program or erase that targets a sector whose `prot` bit is set (sector = address bits 18..16) is not carried out, and that sector is left out of `ers_sectors`.
- R5: Unlocks, 555h/80h, unlocks, 555h/10h issue `ers_start` with `chip_erase`=1 and `ers_sectors` = the inverse of `prot`.
- R6: Unlocks, 555h/80h, unlocks, then data 30h at a sector address open the window (`window_open`=1). A further 30h write adds its sector and restarts the window, which lasts WIN_CYCLES clocks. When the window expires, `ers_start` is issued with the collected one-hot sector set and `chip_erase`=0.
- R7: Inside the window, any write other than 30h or B0h closes the window and returns to array read, and no erase is started.
- R8: While `as_mode`=1, a read at offset 00h (address bits 7..0) returns 37h, 01h returns 86h, 03h returns 7Fh, and 02h returns 01h if the sector selected by `rd_addr` bits 18..16 is protected or 00h if it is not.
- R9: Data F0h at any address, written between sequence cycles or in autoselect mode, returns to the base state without starting anything.
- R10: Data B0h is ignored during chip erase and during program. During a running sector erase it issues `ers_suspend` and sets `erase_suspended`. In the window it closes the window and suspends at once, with no pulse, because the engine has not yet started.
- R11: Data 30h issues `ers_resume` only while `erase_suspended`=1, or `ers_start` if the suspend happened in the window. Repeated resumes and resumes when not suspended are ignored.
- R12: While suspended, a program to a sector in the suspended erase set is rejected and a program to any other sector is accepted. Erase sequences are refused. Leaving autoselect with F0h keeps `erase_suspended`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 19 | Identification read address |
| rd_data | output | 8 | Identification read data, 0 outside autoselect |
| prot | input | 8 | Per-sector protect bits |
| eng_done | input | 1 | Engine completion pulse |
| pgm_start | output | 1 | Program start pulse |
| pgm_addr | output | 19 | Program address |
| pgm_data | output | 8 | Program data |
| ers_start | output | 1 | Erase start pulse |
| ers_sectors | output | 8 | One-hot set of sectors to erase |
| chip_erase | output | 1 | Active erase is a whole-array erase |
| ers_suspend | output | 1 | Suspend pulse to the engine |
| ers_resume | output | 1 | Resume pulse to the engine |
| as_mode | output | 1 | Autoselect mode active |
| window_open | output | 1 | Sector collection window open |
| erase_suspended | output | 1 | Erase is suspended |

## Verification
The hardest situation to reach is a suspend that lands in the collection window. The engine has not been started at that point, so the later resume must become an erase start rather than a resume pulse. The stimulus writes a sector erase and then sends B0h straight away, long before expiry. It then waits past the window length to confirm that nothing starts, and resumes. Window restart is proven by adding a sector at 30 of 40 window cycles and checking that no erase has started 20 cycles later.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int ADDR_W    = 19;
    localparam int DATA_W    = 8;
    localparam int SECT_BITS = 3;
    localparam int NUM_SECT  = 1 << SECT_BITS;
    localparam int CMD_AW    = 11;
    localparam int OFS_W     = 8;

    localparam logic [CMD_AW-1:0] A_FIRST  = 11'h555;
    localparam logic [CMD_AW-1:0] A_SECOND = 11'h2AA;

    localparam logic [DATA_W-1:0] D_KEY1    = 8'hAA;
    localparam logic [DATA_W-1:0] D_KEY2    = 8'h55;
    localparam logic [DATA_W-1:0] D_PROGRAM = 8'hA0;
    localparam logic [DATA_W-1:0] D_ERASE   = 8'h80;
    localparam logic [DATA_W-1:0] D_WHOLE   = 8'h10;
    localparam logic [DATA_W-1:0] D_SECTOR  = 8'h30;
    localparam logic [DATA_W-1:0] D_IDENT   = 8'h90;
    localparam logic [DATA_W-1:0] D_ABORT   = 8'hF0;
    localparam logic [DATA_W-1:0] D_PAUSE   = 8'hB0;
    localparam logic [DATA_W-1:0] D_CONT    = 8'h30;

    localparam logic [DATA_W-1:0] ID_MAKER  = 8'h37;
    localparam logic [DATA_W-1:0] ID_PART   = 8'h86;
    localparam logic [DATA_W-1:0] ID_EXT    = 8'h7F;

    typedef enum logic [3:0] {
        ST_BASE, ST_KEY1, ST_KEY2, ST_PGM_ARM, ST_ERS_ARM,
        ST_ERS_KEY1, ST_ERS_KEY2, ST_IDENT, ST_WINDOW,
        ST_RUN_PGM, ST_RUN_ERS
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic cyc_hit(input logic [CMD_AW-1:0] a, input logic [DATA_W-1:0] d,
                                     input logic [CMD_AW-1:0] ea, input logic [DATA_W-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    function automatic logic [SECT_BITS-1:0] sector_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SECT_BITS];
    endfunction
endpackage

// File: rtl/flash_win_timer.sv
module flash_win_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic stop,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            run <= 1'b1;
            cnt <= CW'(CYCLES - 1);
        end else if (stop) begin
            run <= 1'b0;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0) && !load;
endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux
    import flash_cmd_pkg::*;
(
    input  logic                en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_SECT-1:0] prot,
    output logic [DATA_W-1:0]   rd_data
);
    logic [OFS_W-1:0] ofs;
    logic             unused_mid;

    assign ofs        = rd_addr[OFS_W-1:0];
    assign unused_mid = ^rd_addr[ADDR_W-SECT_BITS-1:OFS_W];

    always_comb begin
        rd_data = '0;
        if (en) begin
            case (ofs)
                8'h00:   rd_data = ID_MAKER;
                8'h01:   rd_data = ID_PART;
                8'h02:   rd_data = {{(DATA_W-1){1'b0}}, prot[sector_of(rd_addr)]};
                8'h03:   rd_data = ID_EXT;
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int WIN_CYCLES = 5000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_SECT-1:0] prot,
    input  logic                eng_done,
    output logic                pgm_start,
    output logic [ADDR_W-1:0]   pgm_addr,
    output logic [DATA_W-1:0]   pgm_data,
    output logic                ers_start,
    output logic [NUM_SECT-1:0] ers_sectors,
    output logic                chip_erase,
    output logic                ers_suspend,
    output logic                ers_resume,
    output logic                as_mode,
    output logic                window_open,
    output logic                erase_suspended
);
    seq_state_e          st_q, st_n;
    logic                susp_q, susp_n, chip_q, chip_n, started_q, started_n;
    logic [NUM_SECT-1:0] mask_q, mask_n;
    logic                pgm_go, ers_go, susp_go, res_go, win_load, win_stop, win_expired;

    bus_wr_t             wr;
    logic [CMD_AW-1:0]   a_lo;
    logic [NUM_SECT-1:0] sect_bit;
    logic                sect_prot;

    assign wr        = '{addr: wr_addr, data: wr_data};
    assign a_lo      = wr.addr[CMD_AW-1:0];
    assign sect_bit  = NUM_SECT'(1) << sector_of(wr.addr);
    assign sect_prot = prot[sector_of(wr.addr)];

    flash_win_timer #(.CYCLES(WIN_CYCLES)) i_win (
        .clk(clk), .rst(rst), .load(win_load), .stop(win_stop), .expired(win_expired)
    );

    flash_id_mux i_id (
        .en(st_q == ST_IDENT), .rd_addr(rd_addr), .prot(prot), .rd_data(rd_data)
    );

    always_comb begin
        st_n = st_q; susp_n = susp_q; chip_n = chip_q; started_n = started_q; mask_n = mask_q;
        pgm_go = 1'b0; ers_go = 1'b0; susp_go = 1'b0; res_go = 1'b0;
        win_load = 1'b0; win_stop = 1'b0;
        case (st_q)
            ST_BASE: if (wr_en) begin
                if (susp_q && wr.data == D_CONT) begin
                    st_n   = ST_RUN_ERS;
                    susp_n = 1'b0;
                    if (started_q) res_go = 1'b1;
                    else begin ers_go = 1'b1; started_n = 1'b1; end
                end else if (cyc_hit(a_lo, wr.data, A_FIRST, D_KEY1)) begin
                    st_n = ST_KEY1;
                end
            end
            ST_KEY1: if (wr_en)
                st_n = cyc_hit(a_lo, wr.data, A_SECOND, D_KEY2) ? ST_KEY2 : ST_BASE;
            ST_KEY2: if (wr_en) begin
                if (cyc_hit(a_lo, wr.data, A_FIRST, D_PROGRAM))                st_n = ST_PGM_ARM;
                else if (cyc_hit(a_lo, wr.data, A_FIRST, D_IDENT))             st_n = ST_IDENT;
                else if (cyc_hit(a_lo, wr.data, A_FIRST, D_ERASE) && !susp_q)  st_n = ST_ERS_ARM;
                else                                                           st_n = ST_BASE;
            end
            ST_PGM_ARM: if (wr_en) begin
                if (sect_prot || (susp_q && (mask_q & sect_bit) != '0)) begin
                    st_n = ST_BASE;
                end else begin
                    pgm_go = 1'b1;
                    st_n   = ST_RUN_PGM;
                end
            end
            ST_ERS_ARM: if (wr_en)
                st_n = cyc_hit(a_lo, wr.data, A_FIRST, D_KEY1) ? ST_ERS_KEY1 : ST_BASE;
            ST_ERS_KEY1: if (wr_en)
                st_n = cyc_hit(a_lo, wr.data, A_SECOND, D_KEY2) ? ST_ERS_KEY2 : ST_BASE;
            ST_ERS_KEY2: if (wr_en) begin
                if (cyc_hit(a_lo, wr.data, A_FIRST, D_WHOLE)) begin
                    mask_n = ~prot;
                    if (~prot != '0) begin
                        chip_n = 1'b1; ers_go = 1'b1; started_n = 1'b1; st_n = ST_RUN_ERS;
                    end else begin
                        st_n = ST_BASE;
                    end
                end else if (wr.data == D_SECTOR) begin
                    mask_n    = sect_prot ? '0 : sect_bit;
                    chip_n    = 1'b0;
                    started_n = 1'b0;
                    win_load  = 1'b1;
                    st_n      = ST_WINDOW;
                end else begin
                    st_n = ST_BASE;
                end
            end
            ST_IDENT: if (wr_en && wr.data == D_ABORT) st_n = ST_BASE;
            ST_WINDOW: begin
                if (wr_en) begin
                    if (wr.data == D_SECTOR) begin
                        if (!sect_prot) mask_n = mask_q | sect_bit;
                        win_load = 1'b1;
                    end else if (wr.data == D_PAUSE) begin
                        win_stop = 1'b1;
                        susp_n   = (mask_q != '0);
                        st_n     = ST_BASE;
                    end else begin
                        win_stop = 1'b1;
                        mask_n   = '0;
                        st_n     = ST_BASE;
                    end
                end else if (win_expired) begin
                    if (mask_q != '0) begin
                        ers_go = 1'b1; started_n = 1'b1; st_n = ST_RUN_ERS;
                    end else begin
                        st_n = ST_BASE;
                    end
                end
            end
            ST_RUN_PGM: if (eng_done) st_n = ST_BASE;
            ST_RUN_ERS: begin
                if (eng_done) begin
                    st_n = ST_BASE; mask_n = '0; chip_n = 1'b0; started_n = 1'b0;
                end else if (wr_en && wr.data == D_PAUSE && !chip_q) begin
                    susp_go = 1'b1; susp_n = 1'b1; st_n = ST_BASE;
                end
            end
            default: st_n = ST_BASE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_BASE; susp_q <= 1'b0; chip_q <= 1'b0; started_q <= 1'b0; mask_q <= '0;
            pgm_start <= 1'b0; ers_start <= 1'b0; ers_suspend <= 1'b0; ers_resume <= 1'b0;
            pgm_addr <= '0; pgm_data <= '0;
        end else begin
            st_q <= st_n; susp_q <= susp_n; chip_q <= chip_n; started_q <= started_n; mask_q <= mask_n;
            pgm_start   <= pgm_go;
            ers_start   <= ers_go;
            ers_suspend <= susp_go;
            ers_resume  <= res_go;
            if (pgm_go) begin
                pgm_addr <= wr.addr;
                pgm_data <= wr.data;
            end
        end
    end

    assign ers_sectors     = mask_q;
    assign chip_erase      = chip_q;
    assign as_mode         = (st_q == ST_IDENT);
    assign window_open     = (st_q == ST_WINDOW);
    assign erase_suspended = susp_q;
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
    import flash_cmd_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [DATA_W-1:0]   rd_data,
    input logic [NUM_SECT-1:0] prot,
    input logic                pgm_start,
    input logic [ADDR_W-1:0]   pgm_addr,
    input logic                ers_start,
    input logic [NUM_SECT-1:0] ers_sectors,
    input logic                chip_erase,
    input logic                ers_suspend,
    input logic                ers_resume,
    input logic                as_mode,
    input logic                window_open,
    input logic                erase_suspended
);
    p_one_start_r3: assert property (@(posedge clk) disable iff (rst)
        !(pgm_start && ers_start));
    p_pgm_unprot_r4: assert property (@(posedge clk) disable iff (rst)
        pgm_start |-> !prot[sector_of(pgm_addr)]);
    p_ers_unprot_r4: assert property (@(posedge clk) disable iff (rst)
        ers_start |-> ((ers_sectors & prot) == '0) && (ers_sectors != '0));
    p_no_start_in_window_r6: assert property (@(posedge clk) disable iff (rst)
        window_open |-> !pgm_start && !ers_start);
    p_maker_code_r8: assert property (@(posedge clk) disable iff (rst)
        (as_mode && rd_addr[OFS_W-1:0] == 8'h00) |-> rd_data == ID_MAKER);
    p_suspend_sector_only_r10: assert property (@(posedge clk) disable iff (rst)
        ers_suspend |-> erase_suspended && !chip_erase);
    p_resume_after_suspend_r11: assert property (@(posedge clk) disable iff (rst)
        ers_resume |-> $past(erase_suspended) && !erase_suspended);
endmodule

bind flash_cmd_decoder flash_cmd_checker i_chk (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data), .prot(prot),
    .pgm_start(pgm_start), .pgm_addr(pgm_addr), .ers_start(ers_start),
    .ers_sectors(ers_sectors), .chip_erase(chip_erase), .ers_suspend(ers_suspend),
    .ers_resume(ers_resume), .as_mode(as_mode), .window_open(window_open),
    .erase_suspended(erase_suspended)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    localparam int WIN = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  prot = '0;
    logic        eng_done = 1'b0;
    logic        pgm_start, ers_start, chip_erase, ers_suspend, ers_resume;
    logic [18:0] pgm_addr;
    logic [7:0]  pgm_data, ers_sectors;
    logic        as_mode, window_open, erase_suspended;

    always #5 clk = ~clk;

    flash_cmd_decoder #(.WIN_CYCLES(WIN)) i_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .prot(prot), .eng_done(eng_done),
        .pgm_start(pgm_start), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .ers_start(ers_start), .ers_sectors(ers_sectors), .chip_erase(chip_erase),
        .ers_suspend(ers_suspend), .ers_resume(ers_resume), .as_mode(as_mode),
        .window_open(window_open), .erase_suspended(erase_suspended)
    );

    typedef enum int { EV_PGM, EV_ERS, EV_SUSP, EV_RES } ev_kind_e;
    typedef struct {
        ev_kind_e    kind;
        logic [18:0] addr;
        logic [7:0]  data;
        logic [7:0]  mask;
        logic        chip;
        string       req;
    } ev_t;

    ev_t exp_q[$];
    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done_flag = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input ev_kind_e k, input logic [18:0] a, input logic [7:0] d,
                             input logic [7:0] m, input logic c, input string req);
        ev_t e;
        e.kind = k; e.addr = a; e.data = d; e.mask = m; e.chip = c; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic got(input ev_kind_e k);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3/R6/R10/R11", "unexpected event kind", k, 32'hFFFF);
            return;
        end
        e = exp_q.pop_front();
        check(e.kind == k, e.req, "event kind", k, e.kind);
        if (k == EV_PGM) begin
            check(pgm_addr == e.addr, e.req, "pgm_addr", pgm_addr, e.addr);
            check(pgm_data == e.data, e.req, "pgm_data", pgm_data, e.data);
        end
        if (k == EV_ERS) begin
            check(ers_sectors == e.mask, e.req, "ers_sectors", ers_sectors, e.mask);
            check(chip_erase == e.chip, e.req, "chip_erase", chip_erase, e.chip);
        end
    endtask

    // monitor: scoreboard side
    always @(negedge clk) begin
        if (!rst) begin
            if (pgm_start)   got(EV_PGM);
            if (ers_start)   got(EV_ERS);
            if (ers_suspend) got(EV_SUSP);
            if (ers_resume)  got(EV_RES);
        end
    end

    task automatic bw(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic unlock();
        bw(19'h00555, 8'hAA); bw(19'h002AA, 8'h55);
    endtask

    task automatic prog(input logic [18:0] a, input logic [7:0] d);
        unlock(); bw(19'h00555, 8'hA0); bw(a, d);
    endtask

    task automatic erase_pre();
        unlock(); bw(19'h00555, 8'h80); unlock();
    endtask

    task automatic drain(input int cyc, input string req);
        repeat (cyc) @(negedge clk);
        check(exp_q.size() == 0, req, "pending expected events", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic finish_op();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic rd_check(input logic [18:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); rd_addr = a; #1;
        check(rd_data == exp, req, "rd_data", rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!as_mode && !window_open && !erase_suspended, "R1", "mode flags",
              {as_mode, window_open, erase_suspended}, 0);
        check(!pgm_start && !ers_start && !ers_suspend && !ers_resume, "R1", "pulses",
              {pgm_start, ers_start, ers_suspend, ers_resume}, 0);

        // R3 program with upper address bits set on unlocks (R2 don't care)
        bw(19'h7F555, 8'hAA); bw(19'h7A2AA, 8'h55); bw(19'h00555, 8'hA0);
        expect_ev(EV_PGM, 19'h12345, 8'h5A, 8'h00, 1'b0, "R2");
        bw(19'h12345, 8'h5A);
        drain(3, "R3");
        // writes while running are ignored (R3)
        bw(19'h00000, 8'hF0);
        prog(19'h11111, 8'h22);
        drain(5, "R3");
        finish_op();

        // R2 bad unlock, then bare write
        bw(19'h00555, 8'hAA); bw(19'h002AB, 8'h55); bw(19'h00555, 8'hA0); bw(19'h01000, 8'h11);
        bw(19'h02000, 8'h33);
        drain(5, "R2");

        // R9 reset between cycles
        unlock(); bw(19'h00000, 8'hF0); bw(19'h00555, 8'hA0); bw(19'h03000, 8'h44);
        drain(5, "R9");

        // R4 protected sector 2
        prot = 8'h04;
        prog(19'h20010, 8'h66);
        drain(5, "R4");
        expect_ev(EV_PGM, 19'h10010, 8'h67, 8'h00, 1'b0, "R4");
        prog(19'h10010, 8'h67);
        drain(3, "R4");
        finish_op();

        // R5 chip erase, suspend ignored (R10)
        expect_ev(EV_ERS, 19'h0, 8'h0, 8'hFB, 1'b1, "R5");
        erase_pre(); bw(19'h00555, 8'h10);
        drain(3, "R5");
        bw(19'h00000, 8'hB0);
        drain(5, "R10");
        check(!erase_suspended, "R10", "suspended during chip erase", erase_suspended, 0);
        finish_op();

        // R6 window collection with restart
        erase_pre(); bw(19'h10000, 8'h30);
        check(window_open, "R6", "window_open", window_open, 1);
        repeat (30) @(negedge clk);
        bw(19'h30000, 8'h30); bw(19'h50000, 8'h30); bw(19'h20000, 8'h30);
        expect_ev(EV_ERS, 19'h0, 8'h0, 8'h2A, 1'b0, "R6");
        repeat (20) @(negedge clk);
        check(exp_q.size() == 1 && window_open, "R6", "window still open after restart",
              {exp_q.size() == 1, window_open}, 3);
        drain(40, "R6");
        check(!window_open, "R6", "window closed", window_open, 0);
        finish_op();

        // R7 abort in window
        erase_pre(); bw(19'h40000, 8'h30);
        bw(19'h00555, 8'hAA);
        check(!window_open, "R7", "window_open after abort", window_open, 0);
        drain(60, "R7");

        // R10 suspend running sector erase, R12 programs, R8 autoselect
        expect_ev(EV_ERS, 19'h0, 8'h0, 8'h01, 1'b0, "R6");
        erase_pre(); bw(19'h00000, 8'h30);
        drain(60, "R6");
        expect_ev(EV_SUSP, 19'h0, 8'h0, 8'h0, 1'b0, "R10");
        bw(19'h00000, 8'hB0);
        drain(2, "R10");
        check(erase_suspended, "R10", "erase_suspended", erase_suspended, 1);
        prog(19'h00100, 8'h12);
        drain(5, "R12");
        expect_ev(EV_PGM, 19'h60010, 8'h77, 8'h00, 1'b0, "R12");
        prog(19'h60010, 8'h77);
        drain(3, "R12");
        finish_op();
        unlock(); bw(19'h00555, 8'h90);
        check(as_mode, "R8", "as_mode", as_mode, 1);
        rd_check(19'h00000, 8'h37, "R8");
        rd_check(19'h00001, 8'h86, "R8");
        rd_check(19'h00003, 8'h7F, "R8");
        rd_check(19'h20002, 8'h01, "R8");
        rd_check(19'h10002, 8'h00, "R8");
        bw(19'h00000, 8'hF0);
        check(!as_mode && erase_suspended, "R12", "exit autoselect to suspended",
              {as_mode, erase_suspended}, 1);
        expect_ev(EV_RES, 19'h0, 8'h0, 8'h0, 1'b0, "R11");
        bw(19'h00000, 8'h30);
        drain(2, "R11");
        bw(19'h00000, 8'h30);
        drain(5, "R11");
        finish_op();

        // R11 resume when not suspended
        bw(19'h00000, 8'h30);
        drain(5, "R11");

        // R10 suspend inside window, R11 resume starts erase
        erase_pre(); bw(19'h70000, 8'h30); bw(19'h00000, 8'hB0);
        check(erase_suspended && !window_open, "R10", "window suspend",
              {erase_suspended, window_open}, 2);
        drain(60, "R10");
        expect_ev(EV_ERS, 19'h0, 8'h0, 8'h80, 1'b0, "R11");
        bw(19'h00000, 8'h30);
        drain(3, "R11");
        finish_op();

        // R8 autoselect outside suspend, unprotected sector
        unlock(); bw(19'h00555, 8'h90);
        rd_check(19'h50002, 8'h00, "R8");
        bw(19'h00000, 8'hF0);
        rd_check(19'h00000, 8'h00, "R9");

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule